// File: doc/BRIEF.md
# Serial DAC Command Writer

This peripheral sits on a simple register port and sends 32-bit command words to an external serial DAC over a three-wire link. The link has three lines: an active-low frame sync, a serial clock and serial data. A single write of the data register starts a complete frame. The writer pulls sync low, presents the most significant bit, and then runs 32 serial clock periods. The receiver takes one bit on each falling serial clock edge, and the command takes effect on the 32nd fall. Sync then returns high and is held high for a guaranteed idle gap before another frame may start.

The same register reads back as a live busy flag. Software polls it until it reads zero and then writes the next command. A ratio input sets how many system clocks each serial clock half-period lasts, so slower converters can be served. A small package function assembles command words from a command code, a channel address and a 16-bit or 12-bit data value.

Top module: `dac_cmd_writer`

## Requirements
- R1: Out of reset and whenever idle, sync_no and sclk_o are both high and bus_rdata_o reads 32'h0.
- R2: A write while idle drives sync_no low at the next clock edge. While sync stays low, sclk_o makes exactly 32 falling edges, and sync_no returns high on the rising edge that follows the 32nd fall.
- R3: The word is sent most-significant bit first (bit 31 first, bit 0 last). sdo_o changes inside a frame only together with a rising sclk_o edge, so it is stable at every falling edge.
- R4: bus_rdata_o reads 32'h1 from the clock after an accepted write until the frame and its idle gap are complete, and 32'h0 otherwise.
- R5: Each sclk_o half-period lasts ratio+1 system clocks, so sync_no stays low for 64*(ratio+1) clocks. A ratio of 0 gives the fastest serial clock, half the system clock rate.
- R6: A write that arrives while busy is ignored. The frame in progress, its length and its data are unchanged, and no second frame follows.
- R7: After each frame, sync_no stays high and the writer stays busy for GAP_CLKS system clocks (at least 1) before a new write is accepted.
- R8: The divider ratio is captured when the frame starts. Changing clk_ratio_i mid-frame does not change that frame's timing.
- R9: The helper places the command in bits 27:24 and the channel address in bits 23:20. A 16-bit value goes in bits 19:4, or a 12-bit value in bits 19:8. All other bits are zero.
- R10: The reference-setup word uses command 4'h8, and bit 0 gives the on (1) or off (0) state. Channel address 4'hF selects all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe for the data register |
| bus_wdata_i | input | 32 | Command word to send |
| bus_rdata_o | output | 32 | Register read value: 1 while busy, 0 when idle |
| clk_ratio_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| sync_no | output | 1 | Active-low frame sync to the DAC |
| sclk_o | output | 1 | Serial clock to the DAC |
| sdo_o | output | 1 | Serial data to the DAC |

## Verification
The bench captures sdo_o on every falling serial clock edge while sync is low. It checks the captured word and the edge count for patterns that expose bit-order or off-by-one errors: alternating bits, only the top bit set, all ones, and a word with both end bits set. A writer that shifted least-significant bit first, or that dropped or added a serial clock cycle, would return a wrong word or a count other than 32. Frame and gap lengths are measured in system clocks at ratios 0 and 3. A divider that miscounted, or that picked up a new ratio mid-frame, would stretch or shrink the frame. The bench also writes mid-frame and polls during the gap. A writer that accepted the mid-frame write would corrupt the word or start a second frame, and one that skipped the gap would report idle too early.

// File: rtl/dac_writer_pkg.sv
package dac_writer_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } frame_state_e;

  localparam logic [3:0] CMD_REF_SETUP = 4'h8;
  localparam logic [3:0] ADDR_ALL      = 4'hF;

  function automatic logic [WORD_W-1:0] pack_w16(input logic [3:0] cmd,
                                                 input logic [3:0] addr,
                                                 input logic [15:0] val);
    return {4'b0, cmd, addr, val, 4'b0};
  endfunction

  function automatic logic [WORD_W-1:0] pack_w12(input logic [3:0] cmd,
                                                 input logic [3:0] addr,
                                                 input logic [11:0] val);
    return {4'b0, cmd, addr, val, 8'b0};
  endfunction

  function automatic logic [WORD_W-1:0] pack_ref(input logic on);
    return {4'b0, CMD_REF_SETUP, ADDR_ALL, 19'b0, on};
  endfunction
endpackage

// File: rtl/dac_sclk_div.sv
module dac_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R5: count never passes the latched ratio
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= ratio_i);
endmodule

// File: rtl/dac_shift_reg.sv
module dac_shift_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         sdo_o,
  output logic         last_o
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     sreg_q;
  logic [CNT_W-1:0] bit_q;

  assign sdo_o  = sreg_q[W-1];
  assign last_o = (bit_q == CNT_W'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      bit_q  <= '0;
    end else if (load_i) begin
      sreg_q <= word_i;
      bit_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[W-2:0], 1'b0};
      bit_q  <= bit_q + 1'b1;
    end
  end

  // R2: no shift beyond the final bit
  a_r2_no_overshift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o);
  a_r3_load_excl_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import dac_writer_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int GAP_CLKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             tick_i,
  input  logic             last_i,
  output logic [DIV_W-1:0] ratio_o,
  output logic             run_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             sclk_o,
  output logic             sync_no,
  output logic             busy_o
);
  localparam int GAP_N = (GAP_CLKS < 1) ? 1 : GAP_CLKS;
  localparam int GAP_W = $clog2(GAP_N + 1);

  frame_state_e     state_q;
  logic             sclk_q, sync_q;
  logic [GAP_W-1:0] gap_q;
  logic [DIV_W-1:0] ratio_q;

  assign load_o  = wr_i && (state_q == ST_IDLE);
  assign run_o   = (state_q == ST_SHIFT);
  assign shift_o = run_o && tick_i && !sclk_q && !last_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign sclk_o  = sclk_q;
  assign sync_no = sync_q;
  assign ratio_o = ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b1;
      sync_q  <= 1'b1;
      gap_q   <= '0;
      ratio_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_i) begin
          state_q <= ST_SHIFT;
          sync_q  <= 1'b0;
          ratio_q <= ratio_i;
        end
        ST_SHIFT: if (tick_i) begin
          sclk_q <= !sclk_q;
          if (!sclk_q && last_i) begin
            state_q <= ST_GAP;
            sync_q  <= 1'b1;
            gap_q   <= '0;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_N - 1)) state_q <= ST_IDLE;
          else                            gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (sync_q && sclk_q));
  a_r4_busy_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q |-> busy_o);
  // R7: sync only falls out of idle, i.e. after the full gap
  a_r7_gap_before_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_q) |-> $past(state_q) == ST_IDLE);
  a_r8_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(ratio_q));
endmodule

// File: rtl/dac_cmd_writer.sv
module dac_cmd_writer
  import dac_writer_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int GAP_CLKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [DIV_W-1:0] clk_ratio_i,
  output logic             sync_no,
  output logic             sclk_o,
  output logic             sdo_o
);
  logic             run, tick, load, shift, last, busy;
  logic [DIV_W-1:0] ratio_q;

  dac_frame_ctrl #(.DIV_W(DIV_W), .GAP_CLKS(GAP_CLKS)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i    (bus_wr_i),
    .ratio_i (clk_ratio_i),
    .tick_i  (tick),
    .last_i  (last),
    .ratio_o (ratio_q),
    .run_o   (run),
    .load_o  (load),
    .shift_o (shift),
    .sclk_o  (sclk_o),
    .sync_no (sync_no),
    .busy_o  (busy)
  );

  dac_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .run_i   (run),
    .ratio_i (ratio_q),
    .tick_o  (tick)
  );

  dac_shift_reg #(.W(WORD_W)) u_sreg (
    .clk_i, .rst_ni,
    .load_i  (load),
    .word_i  (bus_wdata_i),
    .shift_i (shift),
    .sdo_o   (sdo_o),
    .last_o  (last)
  );

  assign bus_rdata_o = {31'b0, busy};

  // R3: data moves only with a rising serial clock inside a frame
  a_r3_sdo_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_no && $past(!sync_no) && !$stable(sdo_o)) |-> $rose(sclk_o));
endmodule

// File: tb/dac_cmd_writer_tb.sv
module dac_cmd_writer_tb;
  import dac_writer_pkg::*;

  localparam int GAP = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  ratio = '0;
  logic        sync_n, sclk, sdo;

  int n_chk = 0, n_fail = 0;
  int nfall = 0, nframe = 0;
  logic [31:0] cap = '0;

  always #2.5 clk = ~clk;

  dac_cmd_writer #(.DIV_W(8), .GAP_CLKS(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .clk_ratio_i(ratio),
    .sync_no(sync_n), .sclk_o(sclk), .sdo_o(sdo)
  );

  always @(negedge sync_n) begin nfall = 0; cap = '0; nframe++; end
  always @(negedge sclk) if (!sync_n) begin cap = {cap[30:0], sdo}; nfall++; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // writes at a negedge; returns busy clocks and busy clocks with sync high
  task automatic run_frame(logic [31:0] w, logic [7:0] r, output int busy_n, output int gap_n);
    @(negedge clk); wr = 1'b1; wdata = w; ratio = r;
    @(negedge clk); wr = 1'b0;
    busy_n = 0; gap_n = 0;
    while (rdata != 0) begin
      busy_n++;
      if (sync_n) gap_n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 sync", 32'(sync_n), 1);
    chk("R1 sclk", 32'(sclk), 1);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_pattern(logic [31:0] w, logic [7:0] r);
    int b, g;
    run_frame(w, r, b, g);
    chk("R3 word msb first", cap, w);
    chk("R2 falls", nfall, 32);
    chk("R5 frame length", b - g, 64 * (r + 1));
    chk("R7 gap clocks", g, GAP);
    chk("R4 idle read", rdata, 0);
    chk("R1 idle sync", 32'(sync_n), 1);
  endtask

  task automatic t_busy_read();
    @(negedge clk); wr = 1'b1; wdata = 32'h1234_5678; ratio = 8'd1;
    @(negedge clk); wr = 1'b0;
    chk("R2 sync low", 32'(sync_n), 0);
    chk("R4 busy read", rdata, 32'h1);
    repeat (40) @(negedge clk);
    chk("R4 busy mid", rdata, 32'h1);
    while (rdata != 0) @(negedge clk);
    chk("R3 word", cap, 32'h1234_5678);
  endtask

  task automatic t_ignore();
    int fr, n;
    @(negedge clk); wr = 1'b1; wdata = 32'hA5A5_0F0F; ratio = 8'd0;
    @(negedge clk); wr = 1'b0;
    fr = nframe; n = 1;
    repeat (10) begin @(negedge clk); n++; end
    wr = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk); wr = 1'b0; n++;
    while (rdata != 0) begin @(negedge clk); n++; end
    chk("R6 word kept", cap, 32'hA5A5_0F0F);
    chk("R6 length kept", n - 1, 64 + GAP);
    repeat (20) @(negedge clk);
    chk("R6 no second frame", nframe, fr);
    chk("R6 sync idle", 32'(sync_n), 1);
  endtask

  task automatic t_gap_write();
    int fr;
    @(negedge clk); wr = 1'b1; wdata = 32'h0000_0001; ratio = 8'd0;
    @(negedge clk); wr = 1'b0;
    while (sync_n == 1'b0) @(negedge clk);
    fr = nframe;
    wr = 1'b1; wdata = 32'h8000_0000;
    @(negedge clk); wr = 1'b0;
    chk("R7 write in gap ignored", 32'(sync_n), 1);
    while (rdata != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R7 no frame from gap write", nframe, fr);
    chk("R7 prior word", cap, 32'h0000_0001);
  endtask

  task automatic t_ratio_change();
    int n;
    @(negedge clk); wr = 1'b1; wdata = 32'hC3C3_3C3C; ratio = 8'd2;
    @(negedge clk); wr = 1'b0; n = 0;
    repeat (20) begin @(negedge clk); n++; end
    ratio = 8'd0;
    while (sync_n == 1'b0) begin @(negedge clk); n++; end
    chk("R8 length uses start ratio", n, 64 * 3);
    chk("R8 word", cap, 32'hC3C3_3C3C);
    while (rdata != 0) @(negedge clk);
  endtask

  task automatic t_pack();
    chk("R9 pack16", pack_w16(4'h3, 4'h2, 16'hABCD), 32'h032A_BCD0);
    chk("R9 pack12", pack_w12(4'h0, 4'h5, 12'hABC), 32'h005A_BC00);
    chk("R10 ref on", pack_ref(1'b1), 32'h08F0_0001);
    chk("R10 ref off", pack_ref(1'b0), 32'h08F0_0000);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pattern(32'hAAAA_5555, 8'd0);
    t_pattern(32'h8000_0000, 8'd0);
    t_pattern(32'hFFFF_FFFF, 8'd3);
    t_pattern(32'h8000_0001, 8'd1);
    t_busy_read();
    t_ignore();
    t_gap_write();
    t_ratio_change();
    t_pattern(pack_w16(4'h3, 4'hF, 16'h1357), 8'd0);
    t_pack();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule